// File: doc/BRIEF.md
# Converter Result Read Port

This block is the host-facing output stage of a sampling converter. It keeps the most recent completed conversion result in a data register and presents it on a parallel data bus when a host selects the port and strobes a read. The bus is modelled as a data vector plus an output-enable. A bus buffer above the block turns the enable into a three-state driver. All bus timing is counted in system clocks, and every input is sampled on the rising edge of the block clock.

The conversion sequencer supplies the result vector and a busy level. A conversion in progress aborts any read under way. It also marks the held result as stale. The new result is captured on the cycle busy falls. A read strobe that overlaps busy cannot be trusted, so it raises a sticky flag. The flag clears only when a later, clean read completes. A data-valid bit tells the host that a result is waiting that it has not yet read.

Top module: `adc_rdport`

## Requirements
- R1: The output-enable is high in a cycle only if both active-low select and active-low read were low at the previous rising edge. It rises one clock after both are sampled low.
- R2: The output-enable falls one clock after select or read is sampled high. This is the bus relinquish.
- R3: While the output-enable is high, the data bus carries the data register. While it is low, the data bus is all zeros.
- R4: The data register loads the result input only on the edge that first samples busy low after busy was high. At any other time, changes on the result input have no effect and repeated reads return the same value.
- R5: Data-valid is set when a result is loaded. It is cleared by the end of a clean read, meaning a strobe that never overlapped busy.
- R6: Data-valid reads low one clock after busy is sampled high, and stays low for as long as busy stays high.
- R7: A read strobe sampled while busy is high sets the invalid-read flag one clock later. The flag stays set until a clean read completes.
- R8: The end of a strobe that overlapped busy clears neither data-valid nor the invalid-read flag. If such a strobe ends on the load edge, data-valid is set.
- R9: After reset, the output-enable, data bus, data-valid and invalid-read flag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Conversion in progress, from the sequencer |
| result_i | input | DATA_W | Conversion result, captured when busy falls |
| sel_n_i | input | 1 | Active-low port select |
| rd_n_i | input | 1 | Active-low read strobe |
| bus_o | output | DATA_W | Data bus value, zero when not enabled |
| bus_oe_o | output | 1 | Data bus output-enable |
| data_valid_o | output | 1 | A loaded result has not yet been read cleanly |
| rd_invalid_o | output | 1 | A read overlapped a conversion since the last clean read |

## Verification
A result load can land on the same edge as the end of a read strobe. The bench arranges this by raising busy in the middle of a held strobe, then dropping busy and releasing the strobe in one cycle. It then expects data-valid set, with the load winning, and the invalid flag kept, because the ending strobe was tainted. A strobe that starts on the very edge busy rises is also covered: it must be flagged invalid at once. A clean read afterwards must return the new value and clear both bits.

// File: rtl/adc_rdport_pkg.sv
package adc_rdport_pkg;

    typedef struct packed {
        logic rise;
        logic fall;
    } busy_evt_t;

    typedef struct packed {
        logic active;
        logic overlap;
        logic clean_end;
    } strobe_evt_t;

endpackage

// File: rtl/adc_rdport_busy_edge.sv
module adc_rdport_busy_edge
    import adc_rdport_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      busy_i,
    output busy_evt_t evt_o
);

    typedef struct packed {
        logic busy;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.busy  = busy_i;
        evt_o.rise = busy_i && !st_q.busy;
        evt_o.fall = !busy_i && st_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/adc_rdport_strobe.sv
module adc_rdport_strobe
    import adc_rdport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_n_i,
    input  logic        rd_n_i,
    input  logic        busy_i,
    output strobe_evt_t evt_o,
    output logic        oe_o
);

    typedef struct packed {
        logic strobe;
        logic taint;
        logic oe;
    } state_t;

    state_t st_d, st_q;
    logic   strobe_now;

    always_comb begin
        strobe_now      = !sel_n_i && !rd_n_i;
        st_d            = st_q;
        st_d.strobe     = strobe_now;
        st_d.oe         = strobe_now;
        st_d.taint      = strobe_now && (st_q.taint || busy_i);
        evt_o.active    = strobe_now;
        evt_o.overlap   = strobe_now && busy_i;
        evt_o.clean_end = st_q.strobe && !strobe_now && !st_q.taint;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oe_o = st_q.oe;

endmodule

// File: rtl/adc_rdport_dreg.sv
module adc_rdport_dreg
    import adc_rdport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  busy_evt_t         busy_evt_i,
    input  strobe_evt_t       strobe_evt_i,
    input  logic [DATA_W-1:0] result_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              invalid_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              invalid;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (busy_evt_i.fall) begin
            st_d.data  = result_i;
            st_d.valid = 1'b1;
        end else if (busy_i) begin
            st_d.valid = 1'b0;
        end else if (strobe_evt_i.clean_end) begin
            st_d.valid = 1'b0;
        end
        if (strobe_evt_i.overlap)        st_d.invalid = 1'b1;
        else if (strobe_evt_i.clean_end) st_d.invalid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o    = st_q.data;
    assign valid_o   = st_q.valid;
    assign invalid_o = st_q.invalid;

endmodule

// File: rtl/adc_rdport.sv
module adc_rdport
    import adc_rdport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              sel_n_i,
    input  logic              rd_n_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              bus_oe_o,
    output logic              data_valid_o,
    output logic              rd_invalid_o
);

    busy_evt_t         busy_evt;
    strobe_evt_t       strobe_evt;
    logic              oe;
    logic [DATA_W-1:0] data_q;

    adc_rdport_busy_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy_i),
        .evt_o  (busy_evt)
    );

    adc_rdport_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n_i (sel_n_i),
        .rd_n_i  (rd_n_i),
        .busy_i  (busy_i),
        .evt_o   (strobe_evt),
        .oe_o    (oe)
    );

    adc_rdport_dreg #(.DATA_W(DATA_W)) u_dreg (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy_i),
        .busy_evt_i   (busy_evt),
        .strobe_evt_i (strobe_evt),
        .result_i     (result_i),
        .data_o       (data_q),
        .valid_o      (data_valid_o),
        .invalid_o    (rd_invalid_o)
    );

    always_comb begin
        bus_oe_o = oe;
        bus_o    = oe ? data_q : '0;
    end

endmodule

// File: rtl/adc_rdport_chk.sv
module adc_rdport_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_i,
    input logic              sel_n_i,
    input logic              rd_n_i,
    input logic              bus_oe_o,
    input logic              data_valid_o,
    input logic              rd_invalid_o,
    input logic              busy_fall,
    input logic [DATA_W-1:0] data_q
);

    AST_OE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> $past(!sel_n_i && !rd_n_i)); // R1

    AST_OE_RELINQUISH: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n_i || rd_n_i) |=> !bus_oe_o); // R2

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_fall |=> $stable(data_q)); // R4

    AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        busy_fall |=> data_valid_o); // R5

    AST_BUSY_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !data_valid_o); // R6

    AST_OVERLAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n_i && !rd_n_i && busy_i) |=> rd_invalid_o); // R7

endmodule

bind adc_rdport adc_rdport_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .sel_n_i      (sel_n_i),
    .rd_n_i       (rd_n_i),
    .bus_oe_o     (bus_oe_o),
    .data_valid_o (data_valid_o),
    .rd_invalid_o (rd_invalid_o),
    .busy_fall    (busy_evt.fall),
    .data_q       (data_q)
);

// File: tb/adc_rdport_bench.sv
module adc_rdport_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         busy = 1'b0;
    logic [W-1:0] result = '0;
    logic         sel_n = 1'b1;
    logic         rd_n = 1'b1;
    logic [W-1:0] bus;
    logic         oe, valid, invalid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_rdport #(.DATA_W(W)) u_adc_rdport (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy),
        .result_i     (result),
        .sel_n_i      (sel_n),
        .rd_n_i       (rd_n),
        .bus_o        (bus),
        .bus_oe_o     (oe),
        .data_valid_o (valid),
        .rd_invalid_o (invalid)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic convert(logic [W-1:0] v);
        busy = 1'b1; result = ~v;
        step();
        step();
        chk("R6", "valid during busy", valid, 0);
        result = v ^ 8'h0F;
        step();
        busy = 1'b0; result = v;
        step();
        result = 8'h5A ^ v;
        chk("R5", "valid after load", valid, 1);
    endtask

    task automatic clean_read(logic [W-1:0] exp, string req);
        sel_n = 1'b0; rd_n = 1'b0;
        step();
        chk("R1", "oe after strobe", oe, 1);
        chk("R3", "bus value", bus, exp);
        step();
        chk(req, "bus held", bus, exp);
        sel_n = 1'b1; rd_n = 1'b1;
        step();
        chk("R2", "oe after release", oe, 0);
        chk("R3", "bus quiet", bus, 0);
        chk("R5", "valid after clean read", valid, 0);
        chk("R7", "flag after clean read", invalid, 0);
    endtask

    task automatic t_reset();
        chk("R9", "oe in reset", oe, 0);
        chk("R9", "bus in reset", bus, 0);
        chk("R9", "valid in reset", valid, 0);
        chk("R9", "flag in reset", invalid, 0);
    endtask

    task automatic t_partial_strobe();
        sel_n = 1'b0; rd_n = 1'b1;
        step(); step();
        chk("R1", "select alone", oe, 0);
        sel_n = 1'b1; rd_n = 1'b0;
        step(); step();
        chk("R1", "read alone", oe, 0);
        chk("R3", "bus idle", bus, 0);
        rd_n = 1'b1;
        step();
    endtask

    task automatic t_basic_and_repeat();
        convert(8'hA5);
        step();
        clean_read(8'hA5, "R4");
        clean_read(8'hA5, "R4");
    endtask

    task automatic t_result_ignored();
        convert(8'h3C);
        result = 8'hFF;
        step(); step();
        chk("R5", "valid unchanged", valid, 1);
        clean_read(8'h3C, "R4");
    endtask

    task automatic t_overlap_coincide();
        convert(8'h11);
        sel_n = 1'b0; rd_n = 1'b0;
        step();
        busy = 1'b1; result = 8'hC3;
        step();
        chk("R7", "flag on overlap", invalid, 1);
        chk("R6", "valid dropped", valid, 0);
        step();
        busy = 1'b0; sel_n = 1'b1; rd_n = 1'b1;
        step();
        chk("R8", "load wins on tainted end", valid, 1);
        chk("R8", "flag kept", invalid, 1);
        step(); step();
        chk("R7", "flag sticky", invalid, 1);
        clean_read(8'hC3, "R4");
    endtask

    task automatic t_start_on_rise();
        sel_n = 1'b0; rd_n = 1'b0; busy = 1'b1; result = 8'h7E;
        step();
        chk("R7", "flag when strobe starts with busy", invalid, 1);
        chk("R1", "bus still enabled", oe, 1);
        sel_n = 1'b1; rd_n = 1'b1;
        step();
        chk("R8", "tainted end keeps flag", invalid, 1);
        busy = 1'b0;
        step();
        chk("R5", "valid after load", valid, 1);
        clean_read(8'h7E, "R4");
    endtask

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_partial_strobe();
        t_basic_and_repeat();
        t_result_ignored();
        t_overlap_coincide();
        t_start_on_rise();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule